// File: doc/BRIEF.md
# Wake Source Flag Register

This block is a 16-bit status and control register that sits in a low-power controller. While the chip is in its deepest sleep state, the register captures which event ended that state. The possible events are eight external interrupt lines, the non-maskable interrupt and the manual reset pin. The register also carries a pin-hold bit. Hardware sets that bit when deep sleep begins, and it keeps the output pins frozen until software releases them after wakeup.

Software reads the register over a simple strobe bus. To clear a bit, software must first read it as 1 and then write 0 to it. The register contents survive the system reset that runs after a wake. Only the power-on reset wipes them.

Top module: `wake_src_flag_reg`

## Requirements
- R1: While `por` is high at a rising clock edge, every stored bit is cleared from that edge on, and every read-armed marker is cleared too. After such a reset, `pin_hold` is 0 and a read returns 0x0000.
- R2: `sys_rst` never changes stored bits or `pin_hold`. It only forces `rd_data` to 0x0000.
- R3: While `sleep_active` is 1, each wake input that is high at a clock edge sets its flag from that edge on. Input `irq_wake[i]` sets bit i, `nmi_wake` sets bit 8 and `mres_wake` sets bit 9. If several wake inputs are high in the same cycle, all of their flags are set.
- R4: While `sleep_active` is 0, the wake inputs have no effect on any bit.
- R5: A `sleep_enter` pulse sets bit 15 at that edge. Output `pin_hold` always equals bit 15.
- R6: If `rd_en` is high at an edge, `rd_data` holds the register value from before that edge, starting one cycle later. Without `rd_en` (and without `sys_rst`), `rd_data` keeps its value.
- R7: Bits 14 to 10 always read as 0, and writing to them has no effect.
- R8: A write with 0 in bit 15 or in bits 9 to 0 clears that bit, provided that bit was returned as 1 by a read since the last write.
- R9: A write of 1 to any bit changes nothing. A write of 0 to a bit that has not been read as 1 since the last write changes nothing.
- R10: Any write disarms every bit. A bit that was read as 1 and then written with 1 is not cleared by a following write of 0.
- R11: When a hardware set and an armed write of 0 hit the same bit in the same cycle, the bit ends up as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | System reset, clears only the read-data register |
| sleep_active | input | 1 | High while in deep sleep; enables wake capture |
| sleep_enter | input | 1 | One-cycle pulse when deep sleep is entered |
| irq_wake | input | 8 | External interrupt wake events |
| nmi_wake | input | 1 | Non-maskable interrupt wake event |
| mres_wake | input | 1 | Manual reset pin wake event |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| pin_hold | output | 1 | Pin-state hold control (bit 15) |

## Verification
The assertions assume the following about the inputs:
- Wake inputs and strobes are synchronous to `clk`.
- `por` is held high for at least two edges at start-up, so that the past values used after reset are defined.
- A read and a write are never issued in the same cycle.

The stimulus meets these assumptions. Every input is driven on the falling edge. Bus operations last one cycle each and are always separated. The only same-cycle overlap that is driven on purpose is a wake event together with a write, which is the case R11 covers.

// File: rtl/wsf_pkg.sv
package wsf_pkg;

  typedef enum logic [2:0] {
    BK_IRQ,
    BK_NMI,
    BK_MRES,
    BK_HOLD,
    BK_RSVD
  } bit_kind_e;

  // Role of bit idx in a register of reg_w bits with irq_n interrupt flags.
  function automatic bit_kind_e kind_of(input int idx, input int reg_w, input int irq_n);
    if (idx == reg_w - 1) return BK_HOLD;
    if (idx < irq_n) return BK_IRQ;
    if (idx == irq_n) return BK_NMI;
    if (idx == irq_n + 1) return BK_MRES;
    return BK_RSVD;
  endfunction

endpackage

// File: rtl/wsf_wake_sampler.sv
module wsf_wake_sampler
  import wsf_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int IRQ_N = 8
) (
  input  logic             sleep_active,
  input  logic             sleep_enter,
  input  logic [IRQ_N-1:0] irq_wake,
  input  logic             nmi_wake,
  input  logic             mres_wake,
  output logic [REG_W-1:0] set_vec
);

  // Wake events count only during deep sleep; the hold bit arms on entry.
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    localparam bit_kind_e K = kind_of(i, REG_W, IRQ_N);
    if (K == BK_IRQ) begin : g_irq
      assign set_vec[i] = sleep_active & irq_wake[i];
    end else if (K == BK_NMI) begin : g_nmi
      assign set_vec[i] = sleep_active & nmi_wake;
    end else if (K == BK_MRES) begin : g_mres
      assign set_vec[i] = sleep_active & mres_wake;
    end else if (K == BK_HOLD) begin : g_hold
      assign set_vec[i] = sleep_enter;
    end else begin : g_rsvd
      assign set_vec[i] = 1'b0;
    end
  end

endmodule

// File: rtl/wsf_bit_cell.sv
module wsf_bit_cell (
  input  logic clk,
  input  logic por,
  input  logic set_i,
  input  logic rd_strobe,
  input  logic wr_strobe,
  input  logic wr_bit,
  output logic flag_o
);

  logic flag_q;
  logic arm_q;
  logic clr_req;

  // A clear needs an earlier read that saw 1 and a write that carries 0.
  assign clr_req = wr_strobe & arm_q & ~wr_bit;

  always_ff @(posedge clk) begin
    if (por) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)        flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;

      if (wr_strobe)                arm_q <= 1'b0;
      else if (rd_strobe && flag_q) arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (por)
    set_i |=> flag_q); // R3

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (por)
    (set_i && wr_strobe && !wr_bit) |=> flag_q); // R11

  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (por)
    $fell(flag_q) |-> ($past(arm_q) && $past(wr_strobe) && !$past(wr_bit))); // R8

  AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (por)
    wr_strobe |=> !arm_q); // R10

endmodule

// File: rtl/wsf_read_port.sv
module wsf_read_port #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             por,
  input  logic             sys_rst,
  input  logic             rd_en,
  input  logic [REG_W-1:0] value,
  output logic [REG_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (por || sys_rst) rd_data <= '0;
    else if (rd_en)     rd_data <= value;
  end

  AST_RD_HOLDS: assert property (@(posedge clk) disable iff (por || sys_rst)
    (!$past(rd_en) && !$past(sys_rst) && !$past(por)) |-> $stable(rd_data)); // R6

endmodule

// File: rtl/wake_src_flag_reg.sv
module wake_src_flag_reg
  import wsf_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int IRQ_N = 8
) (
  input  logic             clk,
  input  logic             por,
  input  logic             sys_rst,
  input  logic             sleep_active,
  input  logic             sleep_enter,
  input  logic [IRQ_N-1:0] irq_wake,
  input  logic             nmi_wake,
  input  logic             mres_wake,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             pin_hold
);

  localparam int EV_W = IRQ_N + 2;

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] value;

  wsf_wake_sampler #(.REG_W(REG_W), .IRQ_N(IRQ_N)) u_sampler (
    .sleep_active (sleep_active),
    .sleep_enter  (sleep_enter),
    .irq_wake     (irq_wake),
    .nmi_wake     (nmi_wake),
    .mres_wake    (mres_wake),
    .set_vec      (set_vec)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_reg
    localparam bit_kind_e K = kind_of(i, REG_W, IRQ_N);
    if (K == BK_RSVD) begin : g_rsvd
      logic rsvd_unused;
      assign rsvd_unused = set_vec[i] ^ wr_data[i];
      assign value[i]    = 1'b0;
    end else begin : g_live
      wsf_bit_cell u_cell (
        .clk       (clk),
        .por       (por),
        .set_i     (set_vec[i]),
        .rd_strobe (rd_en),
        .wr_strobe (wr_en),
        .wr_bit    (wr_data[i]),
        .flag_o    (value[i])
      );
    end
  end

  wsf_read_port #(.REG_W(REG_W)) u_rd (
    .clk     (clk),
    .por     (por),
    .sys_rst (sys_rst),
    .rd_en   (rd_en),
    .value   (value),
    .rd_data (rd_data)
  );

  assign pin_hold = value[REG_W-1];

  logic [EV_W-1:0] ev_bits;
  assign ev_bits = value[EV_W-1:0];

  AST_POR_CLEARS: assert property (@(posedge clk)
    por |=> (value == '0)); // R1

  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (por)
    ((ev_bits & ~$past(ev_bits)) != '0) |-> $past(sleep_active)); // R4

  AST_ENTRY_HOLDS_PINS: assert property (@(posedge clk) disable iff (por)
    sleep_enter |=> pin_hold); // R5

  AST_SYSRST_KEEPS: assert property (@(posedge clk) disable iff (por)
    (sys_rst && !rd_en && !wr_en && !sleep_enter && !sleep_active) |=> $stable(value)); // R2

endmodule

// File: tb/tb_wake_src_flag_reg.sv
module tb_wake_src_flag_reg;

  localparam int REG_W = 16;
  localparam int IRQ_N = 8;
  localparam logic [15:0] LIVE = 16'h83FF;

  logic clk = 0;
  logic por = 1, sys_rst = 0, sleep_active = 0, sleep_enter = 0;
  logic [IRQ_N-1:0] irq_wake = '0;
  logic nmi_wake = 0, mres_wake = 0, rd_en = 0, wr_en = 0;
  logic [REG_W-1:0] wr_data = '0;
  logic [REG_W-1:0] rd_data;
  logic pin_hold;

  int total = 0, bad = 0;
  logic [15:0] mdl = '0, marm = '0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  wake_src_flag_reg #(.REG_W(REG_W), .IRQ_N(IRQ_N)) dut (
    .clk(clk), .por(por), .sys_rst(sys_rst), .sleep_active(sleep_active),
    .sleep_enter(sleep_enter), .irq_wake(irq_wake), .nmi_wake(nmi_wake),
    .mres_wake(mres_wake), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_hold(pin_hold)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected value one cycle after each read strobe.
  initial forever begin
    @(posedge clk);
    if (rd_en) begin
      @(negedge clk);
      if (exp_q.size() != 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic do_read(input string req);
    @(negedge clk);
    rd_en = 1;
    exp_q.push_back(mdl);
    tag_q.push_back(req);
    marm = marm | mdl;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic do_write(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    mdl = mdl & ~(marm & ~d & LIVE);
    marm = '0;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic do_wake(input logic sl, input logic [7:0] irq, input logic n, input logic m);
    @(negedge clk);
    sleep_active = sl; irq_wake = irq; nmi_wake = n; mres_wake = m;
    if (sl) mdl = mdl | {6'b0, m, n, irq};
    @(negedge clk);
    sleep_active = 0; irq_wake = '0; nmi_wake = 0; mres_wake = 0;
  endtask

  task automatic do_enter();
    @(negedge clk);
    sleep_enter = 1;
    mdl[15] = 1'b1;
    @(negedge clk);
    sleep_enter = 0;
  endtask

  task automatic do_por();
    @(negedge clk);
    por = 1;
    mdl = '0; marm = '0;
    repeat (3) @(negedge clk);
    por = 0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por = 0;
    check("R1 pin_hold after por", {15'b0, pin_hold}, 16'h0);
    do_read("R1 reset value");

    do_wake(0, 8'hFF, 1, 1);
    do_read("R4 wake ignored when awake");

    do_enter();
    check("R5 pin_hold set on entry", {15'b0, pin_hold}, 16'h1);
    do_read("R5 bit15 set");

    do_wake(1, 8'h05, 0, 0);
    do_read("R3 irq flags");
    do_wake(1, 8'h80, 1, 1);
    do_read("R3 simultaneous wakes");

    do_write(16'hFFFF);
    do_read("R9 write of ones keeps value");
    do_write(16'hFFFF);
    do_write(16'h0000);
    do_read("R10 disarmed zero write keeps value");

    do_write(16'hFFFE);
    do_read("R8 R7 armed clear of bit0 only");
    @(negedge clk);
    check("R6 rd_data holds without read", rd_data, 16'h8384);

    @(negedge clk);
    sys_rst = 1;
    @(negedge clk);
    sys_rst = 0;
    check("R2 sys_rst zeroes rd_data", rd_data, 16'h0);
    check("R2 pin_hold kept through sys_rst", {15'b0, pin_hold}, 16'h1);
    do_read("R2 value kept through sys_rst");

    // Hardware set of bit2 collides with an armed clear of every bit.
    @(negedge clk);
    sleep_active = 1; irq_wake = 8'h04; wr_en = 1; wr_data = 16'h0000;
    mdl = (mdl & ~(marm & LIVE)) | 16'h0004;
    marm = '0;
    @(negedge clk);
    sleep_active = 0; irq_wake = '0; wr_en = 0;
    check("R8 pin_hold released", {15'b0, pin_hold}, 16'h0);
    do_read("R11 set wins over clear");

    do_write(16'h7C00);
    do_read("R7 reserved writes ignored");

    do_por();
    do_read("R1 por mid-run");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule